// File: doc/BRIEF.md
# Threshold-Flagged Byte FIFO Pair with Automatic Request-to-Send

This block holds one serial channel's transmit and receive byte queues side by side. Each queue is a first-in first-out buffer whose oldest byte is always visible at its output. A one-cycle pop strobe consumes that byte. The parameter `DEPTH` sets the size of both queues and may be 8 or 16.

Each queue produces a level flag from a 2-bit trigger code. The transmit flag measures free space. It rises once the number of empty slots reaches the selected amount, so the sender knows when a burst fits. The receive flag measures stored bytes. It rises once the fill reaches the selected amount. The receive code arrives as two separate bits, because the two halves are programmed in different configuration words.

The block also drives an active-low request-to-send pin. With automatic control enabled, the pin follows the receive queue: it goes high (stop sending) once the receive trigger is met and low again when the fill drops under it. With automatic control disabled, a host-written level drives the pin. Pushes into a full queue are discarded and reported with a one-cycle overrun pulse.

Top module: `fifo_trig_top`

## Requirements
- R1: After reset both counts are 0, `txReady` is 1, `rxReady` is 0, and with `autoRtsEn`=0 and `rtsManual`=0 the pin `rtsN` is 1.
- R2: Each queue returns bytes in push order. The oldest byte is shown on `txOut`/`rxOut` with no pop needed. A lone push raises the count by one at the next clock edge, and a lone pop lowers it by one.
- R3: A push to a full queue with no pop in the same cycle is discarded. The count stays at `DEPTH`, the stored bytes are unchanged, and `txDrop`/`rxDrop` is 1 for exactly the cycle after that edge.
- R4: A pop from an empty queue with no push in the same cycle has no effect. The count stays 0.
- R5: A push and a pop in the same cycle on a full queue are both performed: the count stays `DEPTH`, the next byte moves to the head, and no overrun pulse is raised. On an empty queue, only the push takes effect and the count becomes 1.
- R6: `txReady` is 1 exactly when `DEPTH - txCount` is at least the transmit threshold. The threshold is set by `txTrigSel` codes 00/01/10/11: 8/4/6/1 empty slots for `DEPTH`=8, and 16/6/12/1 for `DEPTH`=16.
- R7: `rxReady` is 1 exactly when `rxCount` is at least the receive threshold. The threshold is set by the code {`rxTrigHi`,`rxTrigLo`} 00/01/10/11: 1/3/6/8 bytes for `DEPTH`=8, and 1/6/12/16 for `DEPTH`=16.
- R8: With `autoRtsEn`=1, `rtsN` is 1 when `rxCount` is at or above the receive threshold and 0 below it, and `rtsManual` has no effect.
- R9: With `autoRtsEn`=0, `rtsN` is the inverse of `rtsManual`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txPush | input | 1 | Write `txData` into the transmit queue |
| txData | input | 8 | Byte to store in the transmit queue |
| txPop | input | 1 | Remove the transmit head byte |
| txOut | output | 8 | Oldest byte of the transmit queue |
| rxPush | input | 1 | Write `rxData` into the receive queue |
| rxData | input | 8 | Byte to store in the receive queue |
| rxPop | input | 1 | Remove the receive head byte |
| rxOut | output | 8 | Oldest byte of the receive queue |
| txTrigSel | input | 2 | Transmit empty-slot trigger code |
| rxTrigHi | input | 1 | Upper bit of the receive trigger code |
| rxTrigLo | input | 1 | Lower bit of the receive trigger code |
| autoRtsEn | input | 1 | Drive `rtsN` from the receive level |
| rtsManual | input | 1 | Host request level used when automatic control is off |
| txCount | output | $clog2(DEPTH+1) | Bytes held in the transmit queue |
| rxCount | output | $clog2(DEPTH+1) | Bytes held in the receive queue |
| txReady | output | 1 | Transmit free-space trigger met |
| rxReady | output | 1 | Receive fill trigger met |
| rtsN | output | 1 | Active-low request-to-send |
| txDrop | output | 1 | Transmit overrun pulse |
| rxDrop | output | 1 | Receive overrun pulse |

## Verification
A write and a read can land on the same queue in the same cycle, and the result depends on the fill level at that moment. On a full queue, the read frees the slot the write needs. On an empty queue, the read has nothing to take. The bench provokes both cases by raising push and pop on the same falling edge, once at full and once at empty. It then judges the count, the overrun pulse and the head byte one edge later. A separate case pushes into a full queue without a pop and confirms that only the overrun pulse appears.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;

  typedef struct packed {
    logic txWr;
    logic txRd;
    logic rxWr;
    logic rxRd;
  } fifoStrobe_t;

  // Empty-slot threshold for the transmit queue.
  function automatic int txThr(input logic [1:0] code, input int depth);
    if (depth >= 16) begin
      case (code)
        2'b00:   return depth;
        2'b01:   return 6;
        2'b10:   return 12;
        default: return 1;
      endcase
    end else begin
      case (code)
        2'b00:   return depth;
        2'b01:   return 4;
        2'b10:   return 6;
        default: return 1;
      endcase
    end
  endfunction

  // Held-byte threshold for the receive queue.
  function automatic int rxThr(input logic [1:0] code, input int depth);
    if (depth >= 16) begin
      case (code)
        2'b00:   return 1;
        2'b01:   return 6;
        2'b10:   return 12;
        default: return depth;
      endcase
    end else begin
      case (code)
        2'b00:   return 1;
        2'b01:   return 3;
        2'b10:   return 6;
        default: return depth;
      endcase
    end
  endfunction

endpackage

// File: rtl/fifo_trig_ctrl.sv
module fifo_trig_ctrl
  import fifo_trig_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          txPush,
  input  logic          txPop,
  input  logic          rxPush,
  input  logic          rxPop,
  input  logic [CW-1:0] txCount,
  input  logic [CW-1:0] rxCount,
  input  logic [1:0]    txTrigSel,
  input  logic          rxTrigHi,
  input  logic          rxTrigLo,
  input  logic          autoRtsEn,
  input  logic          rtsManual,
  output fifoStrobe_t   strobe,
  output logic          txDrop,
  output logic          rxDrop,
  output logic          txReady,
  output logic          rxReady,
  output logic          rtsN
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic txFull, rxFull, txRdOk, rxRdOk, txWrOk, rxWrOk;
  logic [CW-1:0] txFree, txLimit, rxLimit;

  // A read only happens when data exists; a write needs room or a same-cycle read.
  always_comb begin
    txFull = (txCount == FULL);
    rxFull = (rxCount == FULL);
    txRdOk = txPop && (txCount != '0);
    rxRdOk = rxPop && (rxCount != '0);
    txWrOk = txPush && (!txFull || txRdOk);
    rxWrOk = rxPush && (!rxFull || rxRdOk);
    strobe.txWr = txWrOk;
    strobe.txRd = txRdOk;
    strobe.rxWr = rxWrOk;
    strobe.rxRd = rxRdOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txDrop <= 1'b0;
      rxDrop <= 1'b0;
    end else begin
      txDrop <= txPush && !txWrOk;
      rxDrop <= rxPush && !rxWrOk;
    end
  end

  always_comb begin
    txFree  = FULL - txCount;
    txLimit = CW'(txThr(txTrigSel, DEPTH));
    rxLimit = CW'(rxThr({rxTrigHi, rxTrigLo}, DEPTH));
    txReady = (txFree >= txLimit);
    rxReady = (rxCount >= rxLimit);
    rtsN    = autoRtsEn ? rxReady : ~rtsManual;
  end

endmodule

// File: rtl/fifo_trig_dpath.sv
module fifo_trig_dpath
  import fifo_trig_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobe_t   strobe,
  input  logic [7:0]    txData,
  input  logic [7:0]    rxData,
  output logic [7:0]    txOut,
  output logic [7:0]    rxOut,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount
);

  logic [1:0]         wrV, rdV;
  logic [1:0][7:0]    inV, headV;
  logic [1:0][CW-1:0] cntV;

  assign wrV = {strobe.rxWr, strobe.txWr};
  assign rdV = {strobe.rxRd, strobe.txRd};
  assign inV = {rxData, txData};

  for (genvar ch = 0; ch < 2; ch++) begin : gQueue
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wrPtr, rdPtr;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (wrV[ch]) mem[wrPtr] <= inV[ch];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        cnt   <= '0;
      end else begin
        if (wrV[ch]) wrPtr <= wrPtr + 1'b1;
        if (rdV[ch]) rdPtr <= rdPtr + 1'b1;
        case ({wrV[ch], rdV[ch]})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end

    assign headV[ch] = mem[rdPtr];
    assign cntV[ch]  = cnt;
  end

  assign txOut   = headV[0];
  assign rxOut   = headV[1];
  assign txCount = cntV[0];
  assign rxCount = cntV[1];

endmodule

// File: rtl/fifo_trig_top.sv
module fifo_trig_top
  import fifo_trig_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          txPush,
  input  logic [7:0]    txData,
  input  logic          txPop,
  output logic [7:0]    txOut,
  input  logic          rxPush,
  input  logic [7:0]    rxData,
  input  logic          rxPop,
  output logic [7:0]    rxOut,
  input  logic [1:0]    txTrigSel,
  input  logic          rxTrigHi,
  input  logic          rxTrigLo,
  input  logic          autoRtsEn,
  input  logic          rtsManual,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount,
  output logic          txReady,
  output logic          rxReady,
  output logic          rtsN,
  output logic          txDrop,
  output logic          rxDrop
);

  fifoStrobe_t strobe;

  fifo_trig_ctrl #(.DEPTH(DEPTH), .CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN),
    .txPush(txPush), .txPop(txPop), .rxPush(rxPush), .rxPop(rxPop),
    .txCount(txCount), .rxCount(rxCount),
    .txTrigSel(txTrigSel), .rxTrigHi(rxTrigHi), .rxTrigLo(rxTrigLo),
    .autoRtsEn(autoRtsEn), .rtsManual(rtsManual),
    .strobe(strobe), .txDrop(txDrop), .rxDrop(rxDrop),
    .txReady(txReady), .rxReady(rxReady), .rtsN(rtsN)
  );

  fifo_trig_dpath #(.DEPTH(DEPTH), .CW(CW)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txData(txData), .rxData(rxData),
    .txOut(txOut), .rxOut(rxOut),
    .txCount(txCount), .rxCount(rxCount)
  );

endmodule

// File: rtl/fifo_trig_chk.sv
module fifo_trig_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          txPush,
  input logic          txPop,
  input logic          rxPush,
  input logic          rxPop,
  input logic          autoRtsEn,
  input logic          rtsManual,
  input logic [CW-1:0] txCount,
  input logic [CW-1:0] rxCount,
  input logic          rxReady,
  input logic          rtsN,
  input logic          txDrop
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= FULL) && (rxCount <= FULL)); // R3

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (txPush && !txPop && txCount != FULL) |=> (txCount == $past(txCount) + 1'b1)); // R2

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (txPush && !txPop && txCount == FULL) |=> (txDrop && txCount == FULL)); // R3

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    (rxPop && !rxPush && rxCount == '0) |=> (rxCount == '0)); // R4

  AST_FULL_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (txPush && txPop && txCount == FULL) |=> (!txDrop && txCount == FULL)); // R5

  AST_AUTO_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (autoRtsEn && rxCount == '0) |-> (!rtsN && !rxReady)); // R8

  AST_MANUAL_PIN: assert property (@(posedge clk) disable iff (!rstN)
    (!autoRtsEn) |-> (rtsN == !rtsManual)); // R9

endmodule

bind fifo_trig_top fifo_trig_chk #(.DEPTH(DEPTH), .CW(CW)) uChk (
  .clk(clk), .rstN(rstN),
  .txPush(txPush), .txPop(txPop), .rxPush(rxPush), .rxPop(rxPop),
  .autoRtsEn(autoRtsEn), .rtsManual(rtsManual),
  .txCount(txCount), .rxCount(rxCount),
  .rxReady(rxReady), .rtsN(rtsN), .txDrop(txDrop)
);

// File: tb/fifo_trig_top_test.sv
module fifo_trig_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int CW         = $clog2(DEPTH + 1);

  // {isRx, code[1:0], level[4:0], expectedReady}
  localparam logic [8:0] VEC [16] = '{
    9'b0_00_00000_1, 9'b0_00_00001_0, 9'b0_01_00100_1, 9'b0_01_00101_0,
    9'b0_10_00010_1, 9'b0_10_00011_0, 9'b0_11_00111_1, 9'b0_11_01000_0,
    9'b1_00_00000_0, 9'b1_00_00001_1, 9'b1_01_00010_0, 9'b1_01_00011_1,
    9'b1_10_00101_0, 9'b1_10_00110_1, 9'b1_11_00111_0, 9'b1_11_01000_1
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic txPush = 0, txPop = 0, rxPush = 0, rxPop = 0;
  logic [7:0] txData = 0, rxData = 0, txOut, rxOut;
  logic [1:0] txTrigSel = 0;
  logic rxTrigHi = 0, rxTrigLo = 0, autoRtsEn = 0, rtsManual = 0;
  logic [CW-1:0] txCount, rxCount;
  logic txReady, rxReady, rtsN, txDrop, rxDrop;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_trig_top #(.DEPTH(DEPTH)) uut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pushOne(input bit isRx, input logic [7:0] d);
    @(negedge clk);
    if (isRx) begin rxPush = 1; rxData = d; end
    else begin txPush = 1; txData = d; end
    @(negedge clk);
    rxPush = 0; txPush = 0;
  endtask

  task automatic popOne(input bit isRx);
    @(negedge clk);
    if (isRx) rxPop = 1; else txPop = 1;
    @(negedge clk);
    rxPop = 0; txPop = 0;
  endtask

  task automatic setLevel(input bit isRx, input int lvl);
    while ((isRx ? int'(rxCount) : int'(txCount)) > 0) popOne(isRx);
    for (int i = 0; i < lvl; i++) pushOne(isRx, 8'(8'h10 + i));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    // R1 reset state
    check("R1 txCount", int'(txCount), 0);
    check("R1 rxCount", int'(rxCount), 0);
    check("R1 txReady", int'(txReady), 1);
    check("R1 rxReady", int'(rxReady), 0);
    check("R1 rtsN", int'(rtsN), 1);
    @(negedge clk); rstN = 1;

    // R6 R7 R8 table walk
    autoRtsEn = 1;
    for (int v = 0; v < 16; v++) begin
      logic [8:0] e;
      e = VEC[v];
      if (e[8]) {rxTrigHi, rxTrigLo} = e[7:6]; else txTrigSel = e[7:6];
      setLevel(e[8], int'(e[5:1]));
      #1;
      if (e[8]) begin
        check("R7 rxReady", int'(rxReady), int'(e[0]));
        check("R8 rtsN auto", int'(rtsN), int'(e[0]));
      end else begin
        check("R6 txReady", int'(txReady), int'(e[0]));
      end
    end
    setLevel(0, 0); setLevel(1, 0);
    txTrigSel = 0; {rxTrigHi, rxTrigLo} = 2'b00;

    // R2 order and show-ahead
    pushOne(0, 8'hA1); pushOne(0, 8'hB2); pushOne(0, 8'hC3);
    check("R2 count", int'(txCount), 3);
    check("R2 head0", int'(txOut), 8'hA1);
    popOne(0); check("R2 head1", int'(txOut), 8'hB2);
    popOne(0); check("R2 head2", int'(txOut), 8'hC3);
    popOne(0); check("R2 drained", int'(txCount), 0);
    pushOne(1, 8'h5A); check("R2 rx head", int'(rxOut), 8'h5A);
    popOne(1);

    // R4 pop on empty
    popOne(1); check("R4 rx empty pop", int'(rxCount), 0);
    popOne(0); check("R4 tx empty pop", int'(txCount), 0);

    // R3 overrun on full
    setLevel(0, DEPTH);
    @(negedge clk); txPush = 1; txData = 8'hEE;
    @(negedge clk); txPush = 0;
    check("R3 drop pulse", int'(txDrop), 1);
    check("R3 count held", int'(txCount), DEPTH);
    @(negedge clk);
    check("R3 pulse ends", int'(txDrop), 0);
    check("R3 head kept", int'(txOut), 8'h10);

    // R5 push and pop together on full
    @(negedge clk); txPush = 1; txPop = 1; txData = 8'h77;
    @(negedge clk); txPush = 0; txPop = 0;
    check("R5 full count", int'(txCount), DEPTH);
    check("R5 full no drop", int'(txDrop), 0);
    check("R5 full head", int'(txOut), 8'h11);
    setLevel(0, 0);
    // R5 push and pop together on empty
    @(negedge clk); txPush = 1; txPop = 1; txData = 8'h66;
    @(negedge clk); txPush = 0; txPop = 0;
    check("R5 empty count", int'(txCount), 1);
    check("R5 empty head", int'(txOut), 8'h66);

    // R8 manual ignored in auto mode
    autoRtsEn = 1; rtsManual = 1;
    {rxTrigHi, rxTrigLo} = 2'b11;
    setLevel(1, DEPTH - 1); #1;
    check("R8 below thr manual ignored", int'(rtsN), 0);
    pushOne(1, 8'h01); #1;
    check("R8 at thr", int'(rtsN), 1);
    popOne(1); #1;
    check("R8 reassert", int'(rtsN), 0);

    // R9 manual mode
    autoRtsEn = 0; rtsManual = 1; #1;
    check("R9 manual on", int'(rtsN), 0);
    rtsManual = 0; #1;
    check("R9 manual off", int'(rtsN), 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule